// File: doc/BRIEF.md
# Pipeline Hazard Scoreboard

This block records, in issue order, the destination register of every instruction that has been issued but whose result has not yet been written to the register file. Decode presents up to three register indices each cycle: the two source operands and its own destination. It stalls when any of them matches a live entry. A source match is a read-after-write hazard. A destination match is a write-after-write hazard.

Each issued instruction pushes an entry, and that entry may carry no destination at all. Each retiring instruction pops the oldest entry in the same cycle as its register-file write. The pop is applied before that cycle's searches and push. An instruction retiring this cycle therefore never holds up the instruction being decoded, which reads the freshly written value at the same time. The depth is a parameter: 2 for a three-stage pipeline, 1 for a two-stage one.

Top module: `hazard_scoreboard`

## Requirements
- R1: After reset (rst_ni low) the scoreboard is empty: empty_o=1, full_o=0, and no search port reports a hit.
- R2: An entry pushed with a destination (ins_valid_i=1, ins_has_dst_i=1) makes searches for that index hit from the next cycle on, for as long as it stays live.
- R3: The three search ports (src1, src2, dst) work independently in the same cycle, each comparing its own index against every live entry.
- R4: An entry pushed with ins_has_dst_i=0 takes a slot and counts toward full_o, but no search ever matches it, whatever index it was given.
- R5: A search whose valid input is 0 always returns no hit.
- R6: Pops retire entries oldest first.
- R7: When rem_i=1 and the scoreboard is not empty, the oldest entry is hidden from that same cycle's searches.
- R8: A push is not visible to searches in its own cycle.
- R9: A push while full is dropped unless rem_i=1 in the same cycle, in which case it is accepted and the scoreboard stays full.
- R10: A pop on an empty scoreboard changes nothing, and rem_err_o=1 during that cycle only.
- R11: full_o=1 exactly when DEPTH entries are live, and empty_o=1 exactly when none are live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | 1 | Push an entry this cycle |
| ins_has_dst_i | input | 1 | The pushed instruction writes a register |
| ins_idx_i | input | IDX_W | Destination index of the pushed entry |
| rem_i | input | 1 | Pop the oldest entry this cycle |
| src1_valid_i | input | 1 | Source 1 search enable |
| src1_idx_i | input | IDX_W | Source 1 index |
| src2_valid_i | input | 1 | Source 2 search enable |
| src2_idx_i | input | IDX_W | Source 2 index |
| dst_valid_i | input | 1 | Destination search enable |
| dst_idx_i | input | IDX_W | Destination index to search |
| src1_hit_o | output | 1 | Source 1 matches a live entry |
| src2_hit_o | output | 1 | Source 2 matches a live entry |
| dst_hit_o | output | 1 | Destination matches a live entry |
| full_o | output | 1 | All DEPTH slots live |
| empty_o | output | 1 | No slot live |
| rem_err_o | output | 1 | Pop requested while empty |

## Verification
The hit outputs and rem_err_o are combinational. They are due in the same cycle as the indices and rem_i that produce them. A push or pop shows up in hits, full_o and empty_o only after the next rising edge. The bench drives each vector at the falling edge and samples 1 ns later, still before the rising edge that commits the vector. The expected values in vector n therefore describe the state left by vectors 0 to n-1, together with the combinational effect of vector n's own pop.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_PORTS = 3;
  typedef enum int {
    PORT_SRC1 = 0,
    PORT_SRC2 = 1,
    PORT_DST  = 2
  } sb_port_e;
endpackage

// File: rtl/sb_ptr_ctrl.sv
module sb_ptr_ctrl #(
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ins_valid_i,
  input  logic             rem_i,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [DEPTH-1:0] live_o,
  output logic [DEPTH-1:0] retire_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             rem_err_o
);
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;
  logic             rem_ok, ins_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty_o   = (count_q == '0);
  assign full_o    = (count_q == CNT_W'(DEPTH));
  assign rem_ok    = rem_i && !empty_o;
  assign rem_err_o = rem_i && empty_o;
  // full with a same-cycle pop still accepts the push
  assign ins_ok    = ins_valid_i && (!full_o || rem_ok);
  assign wr_en_o   = ins_ok;
  assign wr_ptr_o  = tail_q;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int off;
      off = (i >= int'(head_q)) ? (i - int'(head_q)) : (i + DEPTH - int'(head_q));
      live_o[i]   = (off < int'(count_q));
      retire_o[i] = rem_ok && (i == int'(head_q));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (rem_ok) head_q <= ptr_inc(head_q);
      if (ins_ok) tail_q <= ptr_inc(tail_q);
      case ({ins_ok, rem_ok})
        2'b10:   count_q <= count_q + CNT_W'(1);
        2'b01:   count_q <= count_q - CNT_W'(1);
        default: count_q <= count_q;
      endcase
    end
  end
endmodule

// File: rtl/sb_store.sv
module sb_store #(
  parameter int DEPTH = 2,
  parameter int IDX_W = 5,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [PTR_W-1:0]            wr_ptr_i,
  input  logic                        wr_has_dst_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  output logic [DEPTH-1:0]            ent_v_o,
  output logic [DEPTH-1:0][IDX_W-1:0] ent_idx_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_v_o[g]   <= 1'b0;
        ent_idx_o[g] <= '0;
      end else if (wr_en_i && (wr_ptr_i == PTR_W'(g))) begin
        ent_v_o[g]   <= wr_has_dst_i;
        ent_idx_o[g] <= wr_idx_i;
      end
    end
  end
endmodule

// File: rtl/sb_match.sv
module sb_match #(
  parameter int DEPTH = 2,
  parameter int IDX_W = 5
) (
  input  logic                        q_valid_i,
  input  logic [IDX_W-1:0]            q_idx_i,
  input  logic [DEPTH-1:0]            live_i,
  input  logic [DEPTH-1:0]            retire_i,
  input  logic [DEPTH-1:0]            ent_v_i,
  input  logic [DEPTH-1:0][IDX_W-1:0] ent_idx_i,
  output logic                        hit_o
);
  logic [DEPTH-1:0] slot_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    // retiring slot is masked: its write lands this cycle
    assign slot_hit[g] = live_i[g] && !retire_i[g] && ent_v_i[g] &&
                         (ent_idx_i[g] == q_idx_i);
  end

  assign hit_o = q_valid_i && (|slot_hit);
endmodule

// File: rtl/hazard_scoreboard.sv
module hazard_scoreboard #(
  parameter int DEPTH = 2,
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ins_valid_i,
  input  logic             ins_has_dst_i,
  input  logic [IDX_W-1:0] ins_idx_i,
  input  logic             rem_i,
  input  logic             src1_valid_i,
  input  logic [IDX_W-1:0] src1_idx_i,
  input  logic             src2_valid_i,
  input  logic [IDX_W-1:0] src2_idx_i,
  input  logic             dst_valid_i,
  input  logic [IDX_W-1:0] dst_idx_i,
  output logic             src1_hit_o,
  output logic             src2_hit_o,
  output logic             dst_hit_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             rem_err_o
);
  import sb_pkg::*;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic                        wr_en;
  logic [PTR_W-1:0]            wr_ptr;
  logic [DEPTH-1:0]            live, retire, ent_v;
  logic [DEPTH-1:0][IDX_W-1:0] ent_idx;
  logic [NUM_PORTS-1:0]            q_valid, hit;
  logic [NUM_PORTS-1:0][IDX_W-1:0] q_idx;

  sb_ptr_ctrl #(.DEPTH(DEPTH)) i_ptr (
    .clk_i, .rst_ni, .ins_valid_i, .rem_i,
    .wr_en_o(wr_en), .wr_ptr_o(wr_ptr), .live_o(live), .retire_o(retire),
    .full_o, .empty_o, .rem_err_o
  );

  sb_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_store (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_ptr_i(wr_ptr),
    .wr_has_dst_i(ins_has_dst_i), .wr_idx_i(ins_idx_i),
    .ent_v_o(ent_v), .ent_idx_o(ent_idx)
  );

  assign q_valid[PORT_SRC1] = src1_valid_i;
  assign q_valid[PORT_SRC2] = src2_valid_i;
  assign q_valid[PORT_DST]  = dst_valid_i;
  assign q_idx[PORT_SRC1]   = src1_idx_i;
  assign q_idx[PORT_SRC2]   = src2_idx_i;
  assign q_idx[PORT_DST]    = dst_idx_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    sb_match #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_match (
      .q_valid_i(q_valid[p]), .q_idx_i(q_idx[p]),
      .live_i(live), .retire_i(retire), .ent_v_i(ent_v), .ent_idx_i(ent_idx),
      .hit_o(hit[p])
    );
  end

  assign src1_hit_o = hit[PORT_SRC1];
  assign src2_hit_o = hit[PORT_SRC2];
  assign dst_hit_o  = hit[PORT_DST];
endmodule

// File: rtl/sb_checker.sv
module sb_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic ins_valid_i,
  input logic rem_i,
  input logic src1_valid_i,
  input logic src2_valid_i,
  input logic dst_valid_i,
  input logic src1_hit_o,
  input logic src2_hit_o,
  input logic dst_hit_o,
  input logic full_o,
  input logic empty_o
);
  // R1
  empty_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !(src1_hit_o || src2_hit_o || dst_hit_o));
  // R2
  push_not_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && !rem_i) |=> !empty_o);
  // R5
  off_port_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src1_valid_i |-> !src1_hit_o) and (!src2_valid_i |-> !src2_hit_o) and
    (!dst_valid_i |-> !dst_hit_o));
  // R9
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !rem_i) |=> full_o);
  // R10
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !ins_valid_i) |=> empty_o);
  // R11
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
endmodule

bind hazard_scoreboard sb_checker i_sb_checker (
  .clk_i, .rst_ni, .ins_valid_i, .rem_i, .src1_valid_i, .src2_valid_i,
  .dst_valid_i, .src1_hit_o, .src2_hit_o, .dst_hit_o, .full_o, .empty_o
);

// File: tb/test_hazard_scoreboard.sv
`timescale 1ns/1ps
module test_hazard_scoreboard;
  localparam int IDX_W = 5;

  typedef struct packed {
    logic iv; logic id; logic [4:0] ii; logic rm;
    logic s1v; logic [4:0] s1; logic s2v; logic [4:0] s2;
    logic dv; logic [4:0] d;
    logic [5:0] ex;   // {src1_hit, src2_hit, dst_hit, full, empty, rem_err}
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    // R1 idle after reset
    '{1'b0,1'b0,5'd0,1'b0, 1'b1,5'd3,1'b1,5'd3,1'b1,5'd3, 6'b000010, 4'd1},
    // R8 push 3, same-cycle search misses
    '{1'b1,1'b1,5'd3,1'b0, 1'b1,5'd3,1'b0,5'd0,1'b0,5'd0, 6'b000010, 4'd8},
    // R2 R3 push no-dst(9); 3 hits on src1 and dst, 9 misses
    '{1'b1,1'b0,5'd9,1'b0, 1'b1,5'd3,1'b1,5'd9,1'b1,5'd3, 6'b101000, 4'd2},
    // R4 full; no-dst 9 never matches; push 5 dropped (R9)
    '{1'b1,1'b1,5'd5,1'b0, 1'b1,5'd9,1'b1,5'd3,1'b1,5'd5, 6'b010100, 4'd4},
    // R5 R9 disabled src1 on 3 quiet; 5 absent
    '{1'b0,1'b0,5'd0,1'b0, 1'b0,5'd3,1'b1,5'd3,1'b1,5'd5, 6'b010100, 4'd5},
    // R7 pop 3 + push 7 while full: 3 hidden, 7 not yet visible
    '{1'b1,1'b1,5'd7,1'b1, 1'b1,5'd3,1'b1,5'd7,1'b1,5'd3, 6'b000100, 4'd7},
    // R9 push accepted with pop: full with 7
    '{1'b0,1'b0,5'd0,1'b0, 1'b1,5'd3,1'b1,5'd7,1'b1,5'd7, 6'b011100, 4'd9},
    // R6 pop retires no-dst entry, 7 still hits
    '{1'b0,1'b0,5'd0,1'b1, 1'b0,5'd0,1'b0,5'd0,1'b1,5'd7, 6'b001100, 4'd6},
    // R6 7 remains alone
    '{1'b0,1'b0,5'd0,1'b0, 1'b1,5'd7,1'b0,5'd0,1'b0,5'd0, 6'b100000, 4'd6},
    // R7 pop 7 hides it
    '{1'b0,1'b0,5'd0,1'b1, 1'b1,5'd7,1'b0,5'd0,1'b0,5'd0, 6'b000000, 4'd7},
    // R10 pop on empty
    '{1'b0,1'b0,5'd0,1'b1, 1'b0,5'd0,1'b0,5'd0,1'b0,5'd0, 6'b000011, 4'd10},
    // R10 error gone, still empty; push 4
    '{1'b1,1'b1,5'd4,1'b0, 1'b0,5'd0,1'b0,5'd0,1'b0,5'd0, 6'b000010, 4'd10},
    // R11 one live: neither flag; push 6
    '{1'b1,1'b1,5'd6,1'b0, 1'b1,5'd4,1'b0,5'd0,1'b0,5'd0, 6'b100000, 4'd11},
    // R11 R3 two live after earlier empty pop: full
    '{1'b0,1'b0,5'd0,1'b0, 1'b1,5'd4,1'b1,5'd6,1'b1,5'd1, 6'b110100, 4'd11}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ins_valid_i = 0, ins_has_dst_i = 0, rem_i = 0;
  logic [IDX_W-1:0] ins_idx_i = '0;
  logic src1_valid_i = 0, src2_valid_i = 0, dst_valid_i = 0;
  logic [IDX_W-1:0] src1_idx_i = '0, src2_idx_i = '0, dst_idx_i = '0;
  logic src1_hit_o, src2_hit_o, dst_hit_o, full_o, empty_o, rem_err_o;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  hazard_scoreboard #(.DEPTH(2), .IDX_W(IDX_W)) i_hazard_scoreboard (.*);

  task automatic chk(input logic [5:0] exp, input int rq, input int n);
    logic [5:0] act;
    act = {src1_hit_o, src2_hit_o, dst_hit_o, full_o, empty_o, rem_err_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d step %0d: got %b expected %b", rq, n, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    ins_valid_i = v.iv; ins_has_dst_i = v.id; ins_idx_i = v.ii; rem_i = v.rm;
    src1_valid_i = v.s1v; src1_idx_i = v.s1;
    src2_valid_i = v.s2v; src2_idx_i = v.s2;
    dst_valid_i = v.dv; dst_idx_i = v.d;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int n = 0; n < NV; n++) begin
      @(negedge clk_i);
      drive(VEC[n]);
      #1 chk(VEC[n].ex, int'(VEC[n].rq), n);
    end
    // R1 asynchronous reset while full clears everything
    @(negedge clk_i);
    drive('{1'b0,1'b0,5'd0,1'b0, 1'b1,5'd4,1'b1,5'd6,1'b0,5'd0, 6'b0, 4'd0});
    rst_ni = 1'b0;
    #1 chk(6'b000010, 1, 100);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1 chk(6'b000010, 1, 101);
    // R4 a full scoreboard of no-dst entries never stalls
    @(negedge clk_i);
    drive('{1'b1,1'b0,5'd2,1'b0, 1'b0,5'd0,1'b0,5'd0,1'b0,5'd0, 6'b0, 4'd0});
    @(negedge clk_i);
    @(negedge clk_i);
    drive('{1'b0,1'b0,5'd0,1'b0, 1'b1,5'd2,1'b1,5'd2,1'b1,5'd2, 6'b0, 4'd0});
    #1 chk(6'b000100, 4, 102);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule